// File: doc/BRIEF.md
# SDRAM Device Command Front-End

This block is the control side of a single-data-rate synchronous DRAM seen from inside the device. On every rising clock edge it samples the clock-enable pin, the chip-select pin and the three strobe pins (row, column, write). It turns each sample into one of eight commands, tracks which bank holds an open row, and serves reads and writes from a small register array that stands in for the cell array. Reads use a fixed column latency of two and a burst of one. Each 8-bit byte lane of the data path has its own mask pin.

The block follows two timing rules that a plain decoder would miss. First, a low clock enable stops command interpretation one edge later, and a high clock enable restores it one edge later. Second, the data mask acts on read data with the same two-edge latency as the read itself. On writes, the mask acts in the same cycle as the data.

Top module: `sdcmd_frontend`

## Requirements
- R1: While `rst_n` is low, `cmd_onehot`, `cmd_illegal`, `rdata_oe`, `rdata` and `bank_open` are all zero and `dev_active` is low. The first rising edge after reset release interprets no command.
- R2: With the device active and `cs_n` low, the pins {`ras_n`,`cas_n`,`we_n`} map to one `cmd_onehot` bit, registered at the same edge: 111 to bit 0 (no-op), 011 to bit 1 (activate), 101 to bit 2 (read), 100 to bit 3 (write), 010 to bit 4 (precharge), 001 to bit 5 (auto refresh), 000 to bit 6 (load mode), 110 to bit 7 (burst stop). At most one bit is ever set.
- R3: If `cke` is sampled low at edge n, the command at edge n is still honoured. Commands from edge n+1 onward give an all-zero `cmd_onehot` and change no state.
- R4: If `cke` is sampled high at edge m, commands are honoured again from edge m+1. `dev_active` shows the clock enable sampled at the last edge.
- R5: At an edge where `cs_n` is high, only bit 0 of `cmd_onehot` can be set, and the strobe, bank and address pins have no effect.
- R6: Activate sets `bank_open[ba]` and stores `addr[ROW_W-1:0]` as that bank's row in `open_rows`. Precharge clears `bank_open[ba]`. When `addr[ADDR_W-1]` is 1, precharge clears every bank.
- R7: A read to an open bank at edge n presents the word at {bank, open row, `addr[COL_W-1:0]`} on `rdata`, with all `rdata_oe` lanes high, after edge n+1 and until edge n+2.
- R8: `dqm[l]` sampled high at the edge of a read command holds `rdata_oe[l]` low for that read's data beat and zeroes bits 8l+7..8l of `rdata`.
- R9: A read or write to a bank with no open row sets `cmd_illegal` for one cycle, together with its command bit. It produces no read data and writes nothing.
- R10: A write to an open bank stores `wdata` lane l only where `dqm[l]` is low at the same edge. Masked lanes keep their stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BANK_W | Bank select |
| addr | input | ADDR_W | Row or column address; top bit selects precharge of all banks |
| dqm | input | LANES | Per-lane data mask |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, masked lanes zero |
| rdata_oe | output | LANES | Per-lane read output enable |
| cmd_onehot | output | 8 | Registered decoded command |
| bank_open | output | NUM_BANKS | Open-row flag per bank |
| open_rows | output | NUM_BANKS*ROW_W | Open row address per bank |
| cmd_illegal | output | 1 | Read or write to a closed bank |
| dev_active | output | 1 | Device interprets commands |

## Verification
The assertions assume that the pins are stable around each rising edge and that `cke` holds a known value whenever reset is not asserted. The inhibit and re-enable properties look two edges ahead from a `cke` sample, so they depend on `cke` being defined at every edge. The stimulus meets these assumptions by changing every input only at falling edges and by holding `cke` high through reset. Reads are aimed only at words the stimulus has already written, because the stand-in array has no reset contents.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

  localparam int NUM_CMDS = 8;

  // Bit index of each command in the one-hot vector
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_LMR = 3'd6,
    CMD_BST = 3'd7
  } cmd_e;

  function automatic cmd_e decode_pins(input logic ras_n, input logic cas_n,
                                       input logic we_n);
    cmd_e c;
    unique case ({ras_n, cas_n, we_n})
      3'b111:  c = CMD_NOP;
      3'b011:  c = CMD_ACT;
      3'b101:  c = CMD_RD;
      3'b100:  c = CMD_WR;
      3'b010:  c = CMD_PRE;
      3'b001:  c = CMD_REF;
      3'b000:  c = CMD_LMR;
      default: c = CMD_BST;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
`timescale 1ns/1ps
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  output logic                enabled,
  output logic [NUM_CMDS-1:0] cmd_now,
  output logic [NUM_CMDS-1:0] cmd_q
);

  logic cke_q, cke_d;
  logic [NUM_CMDS-1:0] cmd_d;

  // Clock enable sampled at the previous edge gates the current edge
  always_comb begin
    cke_d   = cke;
    enabled = cke_q;
  end

  always_comb begin
    cmd_now = '0;
    if (cke_q) begin
      if (cs_n) cmd_now[CMD_NOP] = 1'b1;
      else      cmd_now[decode_pins(ras_n, cas_n, we_n)] = 1'b1;
    end
    cmd_d = cmd_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      cke_q <= cke_d;
      cmd_q <= cmd_d;
    end
  end

endmodule

// File: rtl/sdcmd_bank_tracker.sv
`timescale 1ns/1ps
module sdcmd_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_en,
  input  logic                       pre_en,
  input  logic                       pre_all,
  input  logic [BANK_W-1:0]          bank,
  input  logic [ROW_W-1:0]           row,
  output logic [NUM_BANKS-1:0]       open,
  output logic [NUM_BANKS*ROW_W-1:0] rows
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             hit;
    logic             open_d, open_q;
    logic             row_en;
    logic [ROW_W-1:0] row_q;

    always_comb begin
      hit    = (bank == BANK_W'(b));
      row_en = act_en && hit;
      open_d = open_q;
      if (row_en)                        open_d = 1'b1;
      else if (pre_en && (pre_all || hit)) open_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else begin
        open_q <= open_d;
        if (row_en) row_q <= row;
      end
    end

    assign open[b]                   = open_q;
    assign rows[b*ROW_W +: ROW_W]    = row_q;
  end

endmodule

// File: rtl/sdcmd_array.sv
`timescale 1ns/1ps
module sdcmd_array #(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_lane_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);

  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] rd_q;

  // Stand-in cell array, no reset contents
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lane_en[l]) cells[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= cells[rd_addr];
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/sdcmd_read_pipe.sv
`timescale 1ns/1ps
module sdcmd_read_pipe #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_issue,
  input  logic [LANES-1:0] dqm,
  input  logic [DW-1:0]    arr_data,
  output logic [DW-1:0]    dout,
  output logic [LANES-1:0] oe
);

  logic             vld1_q;
  logic [LANES-1:0] mask1_q;
  logic [LANES-1:0] oe_d, oe_q;
  logic [DW-1:0]    dout_d, dout_q;

  // Stage 2: mask captured with the command gates the beat
  always_comb begin
    oe_d = {LANES{vld1_q}} & ~mask1_q;
    for (int l = 0; l < LANES; l++) begin
      dout_d[l*LANE_W +: LANE_W] = oe_d[l] ? arr_data[l*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1_q  <= 1'b0;
      mask1_q <= '0;
      oe_q    <= '0;
      dout_q  <= '0;
    end else begin
      vld1_q  <= rd_issue;
      mask1_q <= dqm;
      oe_q    <= oe_d;
      dout_q  <= dout_d;
    end
  end

  assign dout = dout_q;
  assign oe   = oe_q;

endmodule

// File: rtl/sdcmd_frontend.sv
`timescale 1ns/1ps
module sdcmd_frontend
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 3,
  parameter int COL_W     = 3,
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = ((ROW_W > COL_W) ? ROW_W : COL_W) + 1,
  localparam int DW       = LANES * LANE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BANK_W-1:0]          ba,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANES-1:0]           dqm,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [LANES-1:0]           rdata_oe,
  output logic [NUM_CMDS-1:0]        cmd_onehot,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       cmd_illegal,
  output logic                       dev_active
);

  localparam int AW      = BANK_W + ROW_W + COL_W;
  localparam int ALL_BIT = ADDR_W - 1;

  logic [NUM_CMDS-1:0] cmd_now;
  logic                bank_is_open;
  logic [ROW_W-1:0]    cur_row;
  logic                rw_cmd, rd_issue, wr_issue, illegal_d, illegal_q;
  logic [AW-1:0]       cell_addr;
  logic [DW-1:0]       arr_data;

  sdcmd_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .enabled (dev_active),
    .cmd_now (cmd_now),
    .cmd_q   (cmd_onehot)
  );

  sdcmd_bank_tracker #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_en  (cmd_now[CMD_ACT]),
    .pre_en  (cmd_now[CMD_PRE]),
    .pre_all (addr[ALL_BIT]),
    .bank    (ba),
    .row     (addr[ROW_W-1:0]),
    .open    (bank_open),
    .rows    (open_rows)
  );

  always_comb begin
    bank_is_open = bank_open[ba];
    cur_row      = open_rows[ba*ROW_W +: ROW_W];
    rw_cmd       = cmd_now[CMD_RD] | cmd_now[CMD_WR];
    illegal_d    = rw_cmd & ~bank_is_open;
    rd_issue     = cmd_now[CMD_RD] & bank_is_open;
    wr_issue     = cmd_now[CMD_WR] & bank_is_open;
    cell_addr    = {ba, cur_row, addr[COL_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= illegal_d;
  end

  assign cmd_illegal = illegal_q;

  sdcmd_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_issue),
    .wr_lane_en (~dqm),
    .wr_addr    (cell_addr),
    .wr_data    (wdata),
    .rd_en      (rd_issue),
    .rd_addr    (cell_addr),
    .rd_data    (arr_data)
  );

  sdcmd_read_pipe #(.LANES(LANES), .LANE_W(LANE_W)) u_rpipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (rd_issue),
    .dqm      (dqm),
    .arr_data (arr_data),
    .dout     (rdata),
    .oe       (rdata_oe)
  );

endmodule

// File: rtl/sdcmd_frontend_checker.sv
`timescale 1ns/1ps
module sdcmd_frontend_checker #(
  parameter int NUM_BANKS = 4,
  parameter int LANES     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic                 cs_n,
  input logic [LANES-1:0]     dqm,
  input logic [7:0]           cmd_onehot,
  input logic                 cmd_illegal,
  input logic [LANES-1:0]     rdata_oe,
  input logic [NUM_BANKS-1:0] bank_open
);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_onehot));

  assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> ##2 (cmd_onehot == 8'h00));

  assert_reenable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> ##2 (cmd_onehot != 8'h00));

  assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_onehot[7:1] == 7'd0));

  assert_illegal_rw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_illegal |-> (cmd_onehot[2] || cmd_onehot[3]));

  assert_read_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe != '0) |-> ($past(cmd_onehot[2]) && !$past(cmd_illegal)));

  assert_read_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata_oe & $past(dqm, 2)) == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    assert_open_by_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_open[b]) |-> cmd_onehot[1]);
    assert_close_by_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_open[b]) |-> cmd_onehot[4]);
  end

endmodule

bind sdcmd_frontend sdcmd_frontend_checker #(
  .NUM_BANKS (NUM_BANKS),
  .LANES     (LANES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke         (cke),
  .cs_n        (cs_n),
  .dqm         (dqm),
  .cmd_onehot  (cmd_onehot),
  .cmd_illegal (cmd_illegal),
  .rdata_oe    (rdata_oe),
  .bank_open   (bank_open)
);

// File: tb/sdcmd_frontend_test.sv
`timescale 1ns/1ps
module sdcmd_frontend_test;

  logic        clk, rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [3:0]  addr;
  logic [1:0]  dqm;
  logic [15:0] wdata, rdata;
  logic [1:0]  rdata_oe;
  logic [7:0]  cmd_onehot;
  logic [3:0]  bank_open;
  logic [11:0] open_rows;
  logic        cmd_illegal, dev_active;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sdcmd_frontend uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .cmd_onehot(cmd_onehot), .bank_open(bank_open), .open_rows(open_rows),
    .cmd_illegal(cmd_illegal), .dev_active(dev_active)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic        cke;
    logic        cs_n;
    logic [2:0]  code;   // {ras_n,cas_n,we_n}
    logic [1:0]  ba;
    logic [3:0]  addr;
    logic [1:0]  dqm;
    logic [15:0] wdata;
    logic [7:0]  e_cmd;
    logic        e_ill;
    logic [1:0]  e_oe;
    logic [15:0] e_rd;
    logic [3:0]  e_open;
  } vec_t;

  localparam int NV = 33;
  // Codes: 111 NOP, 011 ACT, 101 RD, 100 WR, 010 PRE, 001 REF, 000 LMR, 110 BST
  localparam vec_t TBL [NV] = '{
    '{4'd9,  1'b1,1'b0,3'b101,2'd0,4'h1,2'b00,16'h0000, 8'h04,1'b1,2'b00,16'h0000,4'b0000}, // R9 read closed bank
    '{4'd6,  1'b1,1'b0,3'b011,2'd0,4'h3,2'b00,16'h0000, 8'h02,1'b0,2'b00,16'h0000,4'b0001}, // R6 open bank0 row3
    '{4'd10, 1'b1,1'b0,3'b100,2'd0,4'h1,2'b00,16'hA1B2, 8'h08,1'b0,2'b00,16'h0000,4'b0001}, // R10
    '{4'd10, 1'b1,1'b0,3'b100,2'd0,4'h2,2'b00,16'hC3D4, 8'h08,1'b0,2'b00,16'h0000,4'b0001}, // R10
    '{4'd7,  1'b1,1'b0,3'b101,2'd0,4'h1,2'b00,16'h0000, 8'h04,1'b0,2'b00,16'h0000,4'b0001}, // R7
    '{4'd7,  1'b1,1'b0,3'b111,2'd0,4'h0,2'b00,16'h0000, 8'h01,1'b0,2'b11,16'hA1B2,4'b0001}, // R7 beat
    '{4'd8,  1'b1,1'b0,3'b101,2'd0,4'h2,2'b01,16'h0000, 8'h04,1'b0,2'b00,16'h0000,4'b0001}, // R8 mask lane0
    '{4'd8,  1'b1,1'b0,3'b111,2'd0,4'h0,2'b00,16'h0000, 8'h01,1'b0,2'b10,16'hC300,4'b0001}, // R8
    '{4'd10, 1'b1,1'b0,3'b100,2'd0,4'h1,2'b10,16'hFFEE, 8'h08,1'b0,2'b00,16'h0000,4'b0001}, // R10 lane1 masked
    '{4'd10, 1'b1,1'b0,3'b101,2'd0,4'h1,2'b00,16'h0000, 8'h04,1'b0,2'b00,16'h0000,4'b0001}, // R10
    '{4'd8,  1'b1,1'b0,3'b101,2'd0,4'h2,2'b10,16'h0000, 8'h04,1'b0,2'b11,16'hA1EE,4'b0001}, // R10 merged word
    '{4'd8,  1'b1,1'b0,3'b111,2'd0,4'h0,2'b00,16'h0000, 8'h01,1'b0,2'b01,16'h00D4,4'b0001}, // R8 mask lane1
    '{4'd5,  1'b1,1'b1,3'b101,2'd0,4'h1,2'b00,16'h0000, 8'h01,1'b0,2'b00,16'h0000,4'b0001}, // R5 deselected read
    '{4'd5,  1'b1,1'b0,3'b111,2'd0,4'h0,2'b00,16'h0000, 8'h01,1'b0,2'b00,16'h0000,4'b0001}, // R5 no beat
    '{4'd2,  1'b1,1'b0,3'b000,2'd0,4'h0,2'b00,16'h0000, 8'h40,1'b0,2'b00,16'h0000,4'b0001}, // R2
    '{4'd2,  1'b1,1'b0,3'b001,2'd0,4'h0,2'b00,16'h0000, 8'h20,1'b0,2'b00,16'h0000,4'b0001}, // R2
    '{4'd2,  1'b1,1'b0,3'b110,2'd0,4'h0,2'b00,16'h0000, 8'h80,1'b0,2'b00,16'h0000,4'b0001}, // R2
    '{4'd6,  1'b1,1'b0,3'b011,2'd2,4'h5,2'b00,16'h0000, 8'h02,1'b0,2'b00,16'h0000,4'b0101}, // R6 open bank2
    '{4'd6,  1'b1,1'b0,3'b010,2'd0,4'h0,2'b00,16'h0000, 8'h10,1'b0,2'b00,16'h0000,4'b0100}, // R6 close bank0
    '{4'd9,  1'b1,1'b0,3'b101,2'd0,4'h1,2'b00,16'h0000, 8'h04,1'b1,2'b00,16'h0000,4'b0100}, // R9
    '{4'd6,  1'b1,1'b0,3'b010,2'd1,4'h8,2'b00,16'h0000, 8'h10,1'b0,2'b00,16'h0000,4'b0000}, // R6 all banks, R9 no beat
    '{4'd9,  1'b1,1'b0,3'b100,2'd3,4'h0,2'b00,16'hDEAD, 8'h08,1'b1,2'b00,16'h0000,4'b0000}, // R9 write closed
    '{4'd3,  1'b0,1'b0,3'b111,2'd0,4'h0,2'b00,16'h0000, 8'h01,1'b0,2'b00,16'h0000,4'b0000}, // R3 still honoured
    '{4'd3,  1'b0,1'b0,3'b011,2'd1,4'h1,2'b00,16'h0000, 8'h00,1'b0,2'b00,16'h0000,4'b0000}, // R3 inhibited
    '{4'd4,  1'b1,1'b0,3'b011,2'd1,4'h1,2'b00,16'h0000, 8'h00,1'b0,2'b00,16'h0000,4'b0000}, // R4 not yet
    '{4'd4,  1'b1,1'b0,3'b011,2'd1,4'h1,2'b00,16'h0000, 8'h02,1'b0,2'b00,16'h0000,4'b0010}, // R4 active
    '{4'd10, 1'b1,1'b0,3'b100,2'd1,4'h0,2'b00,16'h1234, 8'h08,1'b0,2'b00,16'h0000,4'b0010}, // R10
    '{4'd8,  1'b1,1'b0,3'b101,2'd1,4'h0,2'b11,16'h0000, 8'h04,1'b0,2'b00,16'h0000,4'b0010}, // R8 both lanes
    '{4'd8,  1'b1,1'b0,3'b111,2'd0,4'h0,2'b00,16'h0000, 8'h01,1'b0,2'b00,16'h0000,4'b0010}, // R8
    '{4'd7,  1'b1,1'b0,3'b101,2'd1,4'h0,2'b00,16'h0000, 8'h04,1'b0,2'b00,16'h0000,4'b0010}, // R7
    '{4'd7,  1'b0,1'b0,3'b111,2'd0,4'h0,2'b00,16'h0000, 8'h01,1'b0,2'b11,16'h1234,4'b0010}, // R7 beat
    '{4'd3,  1'b1,1'b0,3'b111,2'd0,4'h0,2'b00,16'h0000, 8'h00,1'b0,2'b00,16'h0000,4'b0010}, // R3
    '{4'd4,  1'b1,1'b0,3'b111,2'd0,4'h0,2'b00,16'h0000, 8'h01,1'b0,2'b00,16'h0000,4'b0010}  // R4
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic s, input logic [2:0] c,
                       input logic [1:0] b, input logic [3:0] a,
                       input logic [1:0] m, input logic [15:0] d);
    cke = k; cs_n = s; {ras_n, cas_n, we_n} = c; ba = b; addr = a; dqm = m; wdata = d;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 3'b111, 2'd0, 4'h0, 2'b00, 16'h0000);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", 64'({cmd_onehot, cmd_illegal, rdata_oe, rdata, bank_open, dev_active}), 64'h0);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 3'b011, 2'd0, 4'h2, 2'b00, 16'h0000);
    @(negedge clk);
    // R1 first edge after release interprets nothing; R4 active flag now set
    check("R1 first edge inhibited", 64'({cmd_onehot, bank_open}), 64'h0);
    check("R4 dev_active", 64'(dev_active), 64'h1);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].cke, TBL[i].cs_n, TBL[i].code, TBL[i].ba, TBL[i].addr, TBL[i].dqm, TBL[i].wdata);
      @(negedge clk);
      check($sformatf("R%0d row %0d", TBL[i].req, i),
            64'({cmd_onehot, cmd_illegal, rdata_oe, rdata, bank_open}),
            64'({TBL[i].e_cmd, TBL[i].e_ill, TBL[i].e_oe, TBL[i].e_rd, TBL[i].e_open}));
    end

    // R6 stored row for bank1 is 1
    check("R6 open row bank1", 64'(open_rows[5:3]), 64'h1);

    // R1 reset in the middle of operation
    drive(1'b1, 1'b0, 3'b111, 2'd0, 4'h0, 2'b00, 16'h0000);
    rst_n = 1'b0;
    #1;
    check("R1 mid reset", 64'({cmd_onehot, cmd_illegal, rdata_oe, rdata, bank_open, dev_active}), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 3'b011, 2'd3, 4'h4, 2'b00, 16'h0000);
    @(negedge clk);
    check("R1 first edge after mid reset", 64'({cmd_onehot, bank_open}), 64'h0);
    @(negedge clk);
    check("R4 activate honoured", 64'({cmd_onehot, bank_open}), 64'({8'h02, 4'b1000}));
    check("R6 row bank3", 64'(open_rows[11:9]), 64'h4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule